// File: doc/BRIEF.md
# Scan-Sliced Overlay Pixel Compositor

This block produces the display pixel stream for a small frame-grabber system. While the beam is in active video it drives one display address to three RAMs at once: the captured image, a graphics-mark plane and a menu plane. It then merges the three bytes into one registered output pixel. A nonzero menu byte has the highest priority. A nonzero mark byte comes next. In all other cases the image byte is shown. Outside active video the pixel is blanked to zero.

The block also decides which CPU requests are granted on the four system RAMs: image, mark, menu and CPU scratch.

- The image and scratch RAMs belong to the CPU whenever it asks.
- The mark and menu RAMs belong to the compositor during scan. The CPU may write them only during flyback.
- A CPU request on either overlay plane that is still pending when flyback ends loses its grant in the same cycle that flyback falls. The CPU therefore never holds an overlay plane in a scan cycle.

The RAMs are modelled as asynchronous-read memories: read data is valid in the same cycle as the address.

Top module: `ovl_compositor`

## Requirements
- R1: The request and grant vectors use bit 0 for the image RAM, bit 1 for the mark RAM, bit 2 for the menu RAM and bit 3 for the scratch RAM. Grant bits 0 and 3 equal request bits 0 and 3 in the same cycle, in every scan, flyback and active state.
- R2: Grant bits 1 and 2 are high only when the matching request is high, `flyback` is 1 and `scan_active` is 0. In every other state they are low, so a request during scan is held off until flyback.
- R3: When `flyback` falls while a mark or menu request is still high, the matching grant drops in that same cycle and stays low through the following scan cycles.
- R4: The image, mark and menu read addresses all equal `disp_addr` in every cycle.
- R5: When `scan_active` is 1 and the menu byte is nonzero, the pixel one clock later equals the menu byte.
- R6: When `scan_active` is 1, the menu byte is zero and the mark byte is nonzero, the pixel one clock later equals the mark byte.
- R7: When `scan_active` is 1 and both overlay bytes are zero, the pixel one clock later equals the image byte.
- R8: When `scan_active` is 0, the pixel one clock later is zero, whatever the RAM bytes are.
- R9: While `rst_n` is low, the pixel output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_active | input | 1 | High during visible pixels of the scan period |
| flyback | input | 1 | High during the retrace period when the CPU may write the overlay planes |
| disp_addr | input | ADDR_W | Current display address |
| img_addr | output | ADDR_W | Read address to the image RAM |
| img_rdata | input | PIX_W | Image RAM read data |
| mark_addr | output | ADDR_W | Read address to the mark RAM |
| mark_rdata | input | PIX_W | Mark RAM read data |
| menu_addr | output | ADDR_W | Read address to the menu RAM |
| menu_rdata | input | PIX_W | Menu RAM read data |
| cpu_req | input | 4 | CPU access requests, one bit per RAM |
| cpu_gnt | output | 4 | CPU access grants, one bit per RAM |
| pix_out | output | PIX_W | Registered composite pixel |

## Verification
The hardest case to reach is an overlay request that is still high at the exact cycle flyback ends. The grant must vanish in that cycle, not one cycle later. The bench raises the mark and menu requests inside flyback and keeps them high while it lowers `flyback` on a falling clock edge. It samples the grants before the next rising edge and again after it. For the pixel path, the bench sweeps every one of the 32768 addresses. The RAM contents are arithmetic patterns, so every combination of menu and mark hit occurs, with periodic blanked cycles among them.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int NUM_RAM  = 4;
  localparam int RAM_IMG  = 0;
  localparam int RAM_MARK = 1;
  localparam int RAM_MENU = 2;
  localparam int RAM_SCR  = 3;
  // Planes that the compositor owns during scan
  localparam logic [NUM_RAM-1:0] SCAN_OWNED = 4'b0110;

  typedef enum logic [1:0] {
    LAY_IMAGE = 2'd0,
    LAY_MARK  = 2'd1,
    LAY_MENU  = 2'd2
  } layer_e;

  function automatic layer_e pick_layer(input logic menu_hit, input logic mark_hit);
    if (menu_hit) return LAY_MENU;
    if (mark_hit) return LAY_MARK;
    return LAY_IMAGE;
  endfunction

  function automatic logic slot_open(input logic scan_owned, input logic flyback,
                                     input logic scan_active);
    if (scan_owned) return flyback & ~scan_active;
    return 1'b1;
  endfunction
endpackage

// File: rtl/ovl_arbiter.sv
module ovl_arbiter
  import ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_active,
  input  logic               flyback,
  input  logic [NUM_RAM-1:0] cpu_req,
  output logic [NUM_RAM-1:0] cpu_gnt,
  output logic               cut_evt
);
  logic fly_q;

  for (genvar g = 0; g < NUM_RAM; g++) begin : g_slot
    assign cpu_gnt[g] = cpu_req[g] & slot_open(SCAN_OWNED[g], flyback, scan_active);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fly_q <= 1'b0;
    else        fly_q <= flyback;
  end

  // Overlay request still pending at the end of flyback
  assign cut_evt = fly_q & ~flyback & (|(cpu_req & SCAN_OWNED));
endmodule

// File: rtl/ovl_merge.sv
module ovl_merge
  import ovl_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_active,
  input  logic [PIX_W-1:0] img_byte,
  input  logic [PIX_W-1:0] mark_byte,
  input  logic [PIX_W-1:0] menu_byte,
  output layer_e           layer_sel,
  output logic [PIX_W-1:0] pix_q
);
  localparam logic [PIX_W-1:0] BLANK = '0;
  logic [PIX_W-1:0] pix_d;

  assign layer_sel = pick_layer(menu_byte != BLANK, mark_byte != BLANK);

  always_comb begin
    case (layer_sel)
      LAY_MENU: pix_d = menu_byte;
      LAY_MARK: pix_d = mark_byte;
      default:  pix_d = img_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pix_q <= BLANK;
    else if (scan_active) pix_q <= pix_d;
    else                  pix_q <= BLANK;
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PIX_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_active,
  input  logic               flyback,
  input  logic [ADDR_W-1:0]  disp_addr,
  output logic [ADDR_W-1:0]  img_addr,
  input  logic [PIX_W-1:0]   img_rdata,
  output logic [ADDR_W-1:0]  mark_addr,
  input  logic [PIX_W-1:0]   mark_rdata,
  output logic [ADDR_W-1:0]  menu_addr,
  input  logic [PIX_W-1:0]   menu_rdata,
  input  logic [NUM_RAM-1:0] cpu_req,
  output logic [NUM_RAM-1:0] cpu_gnt,
  output logic [PIX_W-1:0]   pix_out
);
  logic   cut_evt;
  layer_e layer_sel;

  assign img_addr  = disp_addr;
  assign mark_addr = disp_addr;
  assign menu_addr = disp_addr;

  ovl_arbiter arb_i (
    .clk(clk), .rst_n(rst_n), .scan_active(scan_active), .flyback(flyback),
    .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .cut_evt(cut_evt)
  );

  ovl_merge #(.PIX_W(PIX_W)) mrg_i (
    .clk(clk), .rst_n(rst_n), .scan_active(scan_active),
    .img_byte(img_rdata), .mark_byte(mark_rdata), .menu_byte(menu_rdata),
    .layer_sel(layer_sel), .pix_q(pix_out)
  );
endmodule

// File: rtl/ovl_compositor_chk.sv
module ovl_compositor_chk #(
  parameter int ADDR_W = 15,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_active,
  input logic              flyback,
  input logic [ADDR_W-1:0] disp_addr,
  input logic [ADDR_W-1:0] img_addr,
  input logic [ADDR_W-1:0] mark_addr,
  input logic [ADDR_W-1:0] menu_addr,
  input logic [PIX_W-1:0]  img_rdata,
  input logic [PIX_W-1:0]  mark_rdata,
  input logic [PIX_W-1:0]  menu_rdata,
  input logic [3:0]        cpu_req,
  input logic [3:0]        cpu_gnt,
  input logic [PIX_W-1:0]  pix_out,
  input logic              cut_evt
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_PRIVATE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt[0] == cpu_req[0]) && (cpu_gnt[3] == cpu_req[3])); // R1
  AST_OVL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flyback || scan_active) |-> (cpu_gnt[2:1] == 2'b00)); // R2
  AST_OVL_NO_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt[2:1] & ~cpu_req[2:1]) == 2'b00); // R2
  AST_CUT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    cut_evt |-> (cpu_gnt[2:1] == 2'b00)); // R3
  AST_ADDR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (img_addr == disp_addr) && (mark_addr == disp_addr) && (menu_addr == disp_addr)); // R4
  AST_MENU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(scan_active) && ($past(menu_rdata) != '0)
      |-> pix_out == $past(menu_rdata)); // R5
  AST_MARK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(scan_active) && ($past(menu_rdata) == '0) && ($past(mark_rdata) != '0)
      |-> pix_out == $past(mark_rdata)); // R6
  AST_IMAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(scan_active) && ($past(menu_rdata) == '0) && ($past(mark_rdata) == '0)
      |-> pix_out == $past(img_rdata)); // R7
  AST_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(scan_active) |-> pix_out == '0); // R8
endmodule

bind ovl_compositor ovl_compositor_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scan_active(scan_active), .flyback(flyback),
  .disp_addr(disp_addr), .img_addr(img_addr), .mark_addr(mark_addr), .menu_addr(menu_addr),
  .img_rdata(img_rdata), .mark_rdata(mark_rdata), .menu_rdata(menu_rdata),
  .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .pix_out(pix_out), .cut_evt(cut_evt)
);

// File: tb/ovl_compositor_tb_top.sv
module ovl_compositor_tb_top;
  localparam int AW = 15;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_active = 1'b0;
  logic          flyback = 1'b0;
  logic [AW-1:0] disp_addr = '0;
  logic [AW-1:0] img_addr, mark_addr, menu_addr;
  logic [PW-1:0] img_rdata, mark_rdata, menu_rdata, pix_out;
  logic [3:0]    cpu_req = 4'h0;
  logic [3:0]    cpu_gnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // RAM contents as arithmetic patterns
  function automatic logic [PW-1:0] img_pat(input logic [AW-1:0] a);
    return a[7:0] + {1'b0, a[14:8]};
  endfunction
  function automatic logic [PW-1:0] mark_pat(input logic [AW-1:0] a);
    return (a[2:0] == 3'd5) ? (a[10:3] | 8'h80) : 8'h00;
  endfunction
  function automatic logic [PW-1:0] menu_pat(input logic [AW-1:0] a);
    return (a[9:8] == 2'b11) ? (a[7:0] | 8'h01) : 8'h00;
  endfunction

  assign img_rdata  = img_pat(img_addr);
  assign mark_rdata = mark_pat(mark_addr);
  assign menu_rdata = menu_pat(menu_addr);

  ovl_compositor #(.ADDR_W(AW), .PIX_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_active(scan_active), .flyback(flyback),
    .disp_addr(disp_addr), .img_addr(img_addr), .img_rdata(img_rdata),
    .mark_addr(mark_addr), .mark_rdata(mark_rdata), .menu_addr(menu_addr),
    .menu_rdata(menu_rdata), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .pix_out(pix_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] exp_gnt(input logic [3:0] r, input logic fb, input logic act);
    logic open_ovl;
    open_ovl = fb && !act;
    return {r[3], r[2] & open_ovl, r[1] & open_ovl, r[0]};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pa;
    logic          pact;
    logic [PW-1:0] e;
    scan_active = 1'b1;
    disp_addr = 15'h0301;
    repeat (3) @(negedge clk);
    check("R9 reset pixel", pix_out, 0);
    rst_n = 1'b1;

    // Grant table over every request and timing state
    for (int fb = 0; fb < 2; fb++)
      for (int ac = 0; ac < 2; ac++)
        for (int r = 0; r < 16; r++) begin
          @(negedge clk);
          flyback = fb[0]; scan_active = ac[0]; cpu_req = r[3:0];
          #1;
          check("R1 private grants", {cpu_gnt[3], cpu_gnt[0]},
                {exp_gnt(r[3:0], fb[0], ac[0])[3], exp_gnt(r[3:0], fb[0], ac[0])[0]});
          check("R2 overlay grants", cpu_gnt[2:1], exp_gnt(r[3:0], fb[0], ac[0])[2:1]);
        end

    // Flyback ends with overlay requests pending
    @(negedge clk);
    scan_active = 1'b0; flyback = 1'b1; cpu_req = 4'b0110;
    @(negedge clk);
    check("R2 granted in flyback", cpu_gnt, 4'b0110);
    flyback = 1'b0;
    #1;
    check("R3 cut at flyback end", cpu_gnt, 4'b0000);
    @(negedge clk);
    check("R3 stays cut", cpu_gnt, 4'b0000);
    scan_active = 1'b1;
    @(negedge clk);
    check("R3 stays cut in active", cpu_gnt, 4'b0000);
    cpu_req = 4'h0;

    // Full address sweep
    pa = '0; pact = 1'b0;
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      if (a > 0) begin
        if (!pact) begin
          check("R8 blank", pix_out, 0);
        end else if (menu_pat(pa) != 0) begin
          check("R5 menu", pix_out, menu_pat(pa));
        end else if (mark_pat(pa) != 0) begin
          check("R6 mark", pix_out, mark_pat(pa));
        end else begin
          e = img_pat(pa);
          check("R7 image", pix_out, e);
        end
      end
      disp_addr = a[AW-1:0];
      scan_active = (a % 37) != 11;
      #1;
      if (a % 256 == 0)
        check("R4 shared address", {img_addr, mark_addr, menu_addr},
              {a[AW-1:0], a[AW-1:0], a[AW-1:0]});
      pa = a[AW-1:0]; pact = scan_active;
    end
    @(negedge clk);
    check("R5 final menu", pix_out, (pact ? (menu_pat(pa) != 0 ? menu_pat(pa) :
          (mark_pat(pa) != 0 ? mark_pat(pa) : img_pat(pa))) : 8'h00));

    // Reset mid stream clears pixel
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears", pix_out, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule